// File: doc/BRIEF.md
# Write-Protection Arbiter for a Serial Byte Memory

This block sits beside the bus slave of a small serial byte memory and decides, for each write the slave has received, whether a memory write may begin. Three sources of protection feed the decision. A lock flag that software can set but never clear. A second lock flag that software can set and clear again. A hardware protect pin. Either software flag guards only the lower half of the address space. The pin, when high, guards every address, whatever state the flags are in. The flags stand in for nonvolatile cells. A light power-on reset drops the reversible flag but keeps the permanent one. A full reset loads the permanent flag from a parameter.

The bus slave passes special protection commands to the block as a one-cycle strobe with a 3-bit code. One cycle later the block returns a response strobe with an ACK/NACK bit, which the slave puts on the bus. A status query is answered with ACK when the flag it asks about is still unprogrammed. A write to a guarded address still completes on the bus. The block raises a blocked pulse in place of the write-start pulse, so no memory write begins.

Top module: `wp_guard`

## Requirements
- R1: When the synchronized pin level is high, `prot_mode` is 2'b10 and every requested write yields `wr_blocked`, whatever the flags hold.
- R2: With the synchronized pin low and either flag set, `prot_mode` is 2'b01. A write whose address MSB is 0 is blocked, and a write whose address MSB is 1 is started.
- R3: With the synchronized pin low and both flags clear, `prot_mode` is 2'b00 and every write is started.
- R4: A write request in cycle t gives exactly one of `wr_start` or `wr_blocked` in cycle t+1. The decision uses the protection state held before the edge that ends cycle t, so a command issued in the same cycle does not yet apply.
- R5: Command code 3'd1 sets the permanent flag. It answers ACK if the flag was clear and NACK if the flag was already set. No command ever clears the permanent flag.
- R6: Code 3'd2 sets the reversible flag and code 3'd3 clears it, each answering ACK, while the permanent flag is clear. While the permanent flag is set, both codes answer NACK and leave the reversible flag unchanged.
- R7: Code 3'd4 answers ACK exactly when the permanent flag is clear. Code 3'd5 answers ACK exactly when the reversible flag is clear. Neither query changes any state.
- R8: Codes 3'd0, 3'd6 and 3'd7 answer NACK and change nothing.
- R9: Every command strobe produces a single `rsp_valid` pulse in the following cycle, and there is no response without a command.
- R10: `rst_por` clears the reversible flag and keeps the permanent flag. `rst_full` loads the permanent flag from `PERM_INIT` and clears the reversible flag. Both resets clear the response and write pulses and the pin synchronizer.
- R11: The pin passes through `SYNC_STAGES` flip-flops before it acts. Any level other than a driven 1, including an undriven pin, counts as low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_full | input | 1 | Full power-on reset, synchronous, active high; loads `PERM_INIT` |
| rst_por | input | 1 | Power-on reset, synchronous, active high; keeps the permanent flag |
| wp_pin | input | 1 | External hardware protect level |
| cmd_valid | input | 1 | Protection command strobe |
| cmd_code | input | 3 | Protection command code |
| wr_req | input | 1 | A write byte has been received |
| wr_addr | input | ADDR_W | Target byte address of that write |
| wr_start | output | 1 | Pulse: memory write may begin |
| wr_blocked | output | 1 | Pulse: write refused, byte discarded |
| rsp_valid | output | 1 | Command response strobe |
| rsp_ack | output | 1 | 1 = ACK, 0 = NACK |
| perm_locked | output | 1 | Permanent flag state |
| rev_locked | output | 1 | Reversible flag state |
| prot_mode | output | 2 | 00 none, 01 lower half, 10 whole array |

## Verification
The bench builds the block with its defaults: an 8-bit address, a two-stage pin synchronizer and a clear permanent flag at full reset. With an 8-bit address the bench can sweep every address in each protection mode, so the half boundary at 0x7F/0x80 and both ends of the array are checked. Starting with the permanent flag clear lets the bench exercise the reversible flag's set and clear paths first. It then locks the permanent flag and confirms the refusals that follow. A light reset must not undo that lock; only a full reset does.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;

    localparam int CMD_W = 3;

    localparam logic [CMD_W-1:0] CMD_LOCK_PERM  = 3'd1;
    localparam logic [CMD_W-1:0] CMD_LOCK_REV   = 3'd2;
    localparam logic [CMD_W-1:0] CMD_UNLOCK_REV = 3'd3;
    localparam logic [CMD_W-1:0] CMD_ASK_PERM   = 3'd4;
    localparam logic [CMD_W-1:0] CMD_ASK_REV    = 3'd5;

    typedef enum logic [1:0] {
        MODE_OPEN  = 2'b00,
        MODE_LOWER = 2'b01,
        MODE_ALL   = 2'b10
    } prot_mode_e;

    typedef struct packed {
        logic perm;
        logic rev;
    } flags_t;

    typedef struct packed {
        logic valid;
        logic ack;
    } rsp_t;

    typedef struct packed {
        logic start;
        logic blocked;
    } wr_verdict_t;

    function automatic prot_mode_e resolve_mode(input logic pin_hi, input flags_t f);
        if (pin_hi)
            return MODE_ALL;
        else if (f.perm || f.rev)
            return MODE_LOWER;
        else
            return MODE_OPEN;
    endfunction

    function automatic logic addr_guarded(input prot_mode_e m, input logic upper_half);
        case (m)
            MODE_ALL:   return 1'b1;
            MODE_LOWER: return !upper_half;
            default:    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/wp_pin_sync.sv
module wp_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic clr,
    input  logic pin_raw,
    output logic pin_q
);
    logic [STAGES-1:0] chain;
    logic              pin_lvl;

    // only a driven 1 counts as high; an undriven pin reads as low
    assign pin_lvl = (pin_raw === 1'b1);

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (clr) chain <= '0;
                else     chain <= pin_lvl;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (clr) chain <= '0;
                else     chain <= {chain[STAGES-2:0], pin_lvl};
            end
        end
    endgenerate

    assign pin_q = chain[STAGES-1];
endmodule

// File: rtl/wp_flag_store.sv
module wp_flag_store
    import wp_guard_pkg::*;
#(
    parameter logic PERM_INIT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_full,
    input  logic             rst_por,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_code,
    output flags_t           flags,
    output rsp_t             rsp
);
    flags_t nxt;
    logic   ack;

    always_comb begin
        nxt = flags;
        ack = 1'b0;
        case (cmd_code)
            CMD_LOCK_PERM: begin
                ack      = !flags.perm;
                nxt.perm = 1'b1;
            end
            CMD_LOCK_REV: begin
                if (!flags.perm) begin
                    ack     = 1'b1;
                    nxt.rev = 1'b1;
                end
            end
            CMD_UNLOCK_REV: begin
                if (!flags.perm) begin
                    ack     = 1'b1;
                    nxt.rev = 1'b0;
                end
            end
            CMD_ASK_PERM: ack = !flags.perm;
            CMD_ASK_REV:  ack = !flags.rev;
            default:      ack = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst_full) begin
            flags.perm <= PERM_INIT;
            flags.rev  <= 1'b0;
            rsp        <= '0;
        end else if (rst_por) begin
            flags.rev  <= 1'b0;
            rsp        <= '0;
        end else begin
            if (cmd_valid)
                flags <= nxt;
            rsp.valid <= cmd_valid;
            rsp.ack   <= cmd_valid & ack;
        end
    end
endmodule

// File: rtl/wp_addr_gate.sv
module wp_addr_gate
    import wp_guard_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              clr,
    input  prot_mode_e        mode,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    output wr_verdict_t       verdict
);
    localparam int HALF_BIT = ADDR_W - 1;

    logic guarded;

    assign guarded = addr_guarded(mode, wr_addr[HALF_BIT]);

    always_ff @(posedge clk) begin
        if (clr) begin
            verdict <= '0;
        end else begin
            verdict.start   <= wr_req & !guarded;
            verdict.blocked <= wr_req &  guarded;
        end
    end
endmodule

// File: rtl/wp_guard.sv
module wp_guard
    import wp_guard_pkg::*;
#(
    parameter int   ADDR_W      = 8,
    parameter int   SYNC_STAGES = 2,
    parameter logic PERM_INIT   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_full,
    input  logic              rst_por,
    input  logic              wp_pin,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_code,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              wr_start,
    output logic              wr_blocked,
    output logic              rsp_valid,
    output logic              rsp_ack,
    output logic              perm_locked,
    output logic              rev_locked,
    output logic [1:0]        prot_mode
);
    logic        any_rst;
    logic        pin_q;
    flags_t      flags;
    rsp_t        rsp;
    prot_mode_e  mode;
    wr_verdict_t verdict;

    assign any_rst = rst_full | rst_por;

    wp_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .clr     (any_rst),
        .pin_raw (wp_pin),
        .pin_q   (pin_q)
    );

    wp_flag_store #(.PERM_INIT(PERM_INIT)) u_flags (
        .clk       (clk),
        .rst_full  (rst_full),
        .rst_por   (rst_por),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .flags     (flags),
        .rsp       (rsp)
    );

    assign mode = resolve_mode(pin_q, flags);

    wp_addr_gate #(.ADDR_W(ADDR_W)) u_gate (
        .clk     (clk),
        .clr     (any_rst),
        .mode    (mode),
        .wr_req  (wr_req),
        .wr_addr (wr_addr),
        .verdict (verdict)
    );

    assign wr_start    = verdict.start;
    assign wr_blocked  = verdict.blocked;
    assign rsp_valid   = rsp.valid;
    assign rsp_ack     = rsp.ack;
    assign perm_locked = flags.perm;
    assign rev_locked  = flags.rev;
    assign prot_mode   = mode;
endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_full,
    input logic              rst_por,
    input logic              cmd_valid,
    input logic [2:0]        cmd_code,
    input logic              wr_req,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_start,
    input logic              wr_blocked,
    input logic              rsp_valid,
    input logic              rsp_ack,
    input logic              perm_locked,
    input logic              rev_locked,
    input logic [1:0]        prot_mode
);
    a_r1_whole_array_blocked: assert property (@(posedge clk) disable iff (rst_full || rst_por)
        (wr_req && prot_mode == 2'b10) |=> (wr_blocked && !wr_start));

    a_r2_lower_half_blocked: assert property (@(posedge clk) disable iff (rst_full || rst_por)
        (wr_req && !wr_addr[ADDR_W-1] && (perm_locked || rev_locked)) |=> (wr_blocked && !wr_start));

    a_r4_single_verdict: assert property (@(posedge clk) disable iff (rst_full || rst_por)
        !(wr_start && wr_blocked));

    a_r5_perm_sticky: assert property (@(posedge clk) disable iff (rst_full)
        perm_locked |=> perm_locked);

    a_r6_unlock_refused: assert property (@(posedge clk) disable iff (rst_full || rst_por)
        (cmd_valid && cmd_code == 3'd3 && perm_locked) |=> (rsp_valid && !rsp_ack && $stable(rev_locked)));

    a_r6_unlock_done: assert property (@(posedge clk) disable iff (rst_full || rst_por)
        (cmd_valid && cmd_code == 3'd3 && !perm_locked) |=> (rsp_ack && !rev_locked));

    a_r9_response_follows: assert property (@(posedge clk) disable iff (rst_full || rst_por)
        !cmd_valid |=> !rsp_valid);
endmodule

bind wp_guard wp_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_full    (rst_full),
    .rst_por     (rst_por),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .wr_req      (wr_req),
    .wr_addr     (wr_addr),
    .wr_start    (wr_start),
    .wr_blocked  (wr_blocked),
    .rsp_valid   (rsp_valid),
    .rsp_ack     (rsp_ack),
    .perm_locked (perm_locked),
    .rev_locked  (rev_locked),
    .prot_mode   (prot_mode)
);

// File: tb/wp_guard_test.sv
module wp_guard_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 8;
    localparam int SYNC       = 2;
    localparam bit PINIT      = 1'b0;

    logic          clk = 1'b0;
    logic          rst_full = 1'b1;
    logic          rst_por = 1'b0;
    logic          wp_pin = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_code = 3'd0;
    logic          wr_req = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic          wr_start, wr_blocked, rsp_valid, rsp_ack, perm_locked, rev_locked;
    logic [1:0]    prot_mode;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    wp_guard #(.ADDR_W(AW), .SYNC_STAGES(SYNC), .PERM_INIT(PINIT)) uut (
        .clk(clk), .rst_full(rst_full), .rst_por(rst_por), .wp_pin(wp_pin),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_start(wr_start), .wr_blocked(wr_blocked), .rsp_valid(rsp_valid),
        .rsp_ack(rsp_ack), .perm_locked(perm_locked), .rev_locked(rev_locked),
        .prot_mode(prot_mode)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference state
    bit    m_perm, m_rev, m_start, m_blk, m_rv, m_ack, m_in_rst;
    bit    m_pipe[$];
    string m_ack_tag = "R8";

    function automatic int model_mode();
        if (m_pipe[SYNC-1]) return 2;
        if (m_perm || m_rev) return 1;
        return 0;
    endfunction

    initial for (int i = 0; i < SYNC; i++) m_pipe.push_back(1'b0);

    always @(posedge clk) begin
        int  md;
        bit  guard, ack, np, nr;
        if (rst_full || rst_por) begin
            if (rst_full) m_perm = PINIT;
            m_rev = 0; m_start = 0; m_blk = 0; m_rv = 0; m_ack = 0;
            for (int i = 0; i < SYNC; i++) m_pipe[i] = 1'b0;
            m_in_rst = 1;
        end else begin
            m_in_rst = 0;
            md    = model_mode();
            guard = (md == 2) || (md == 1 && wr_addr < (1 << (AW-1)));
            m_start = wr_req && !guard;
            m_blk   = wr_req && guard;
            np = m_perm; nr = m_rev; ack = 0;
            if (cmd_valid) begin
                case (cmd_code)
                    3'd1: begin ack = !m_perm; np = 1; m_ack_tag = "R5"; end
                    3'd2: begin m_ack_tag = "R6"; if (!m_perm) begin ack = 1; nr = 1; end end
                    3'd3: begin m_ack_tag = "R6"; if (!m_perm) begin ack = 1; nr = 0; end end
                    3'd4: begin ack = !m_perm; m_ack_tag = "R7"; end
                    3'd5: begin ack = !m_rev;  m_ack_tag = "R7"; end
                    default: begin ack = 0; m_ack_tag = "R8"; end
                endcase
            end
            m_perm = np; m_rev = nr;
            m_rv  = cmd_valid;
            m_ack = cmd_valid && ack;
            void'(m_pipe.pop_back());
            m_pipe.push_front(wp_pin);
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // compare on every clock, away from the edge
    always @(posedge clk) begin
        string mtag;
        #2;
        if (!done) begin
            if (m_in_rst) begin
                chk("R10 perm", perm_locked, m_perm);
                chk("R10 rev", rev_locked, m_rev);
                chk("R10 pulses", {wr_start, wr_blocked, rsp_valid}, 0);
            end else begin
                case (model_mode())
                    2: mtag = "R1 mode";
                    1: mtag = "R2 mode";
                    default: mtag = "R3 mode";
                endcase
                if (wp_pin != m_pipe[SYNC-1]) mtag = "R11 mode";
                chk(mtag, prot_mode, model_mode());
                chk("R4 wr_start", wr_start, m_start);
                chk("R4 wr_blocked", wr_blocked, m_blk);
                chk("R9 rsp_valid", rsp_valid, m_rv);
                chk({m_ack_tag, " rsp_ack"}, rsp_ack, m_ack);
                chk("R5 perm_locked", perm_locked, m_perm);
                chk("R6 rev_locked", rev_locked, m_rev);
            end
        end
    end

    task automatic cyc(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic cmd(logic [2:0] c);
        @(negedge clk);
        cmd_valid = 1; cmd_code = c;
        @(negedge clk);
        cmd_valid = 0; cmd_code = 3'd0;
    endtask

    task automatic sweep(int step);
        for (int a = 0; a < (1 << AW); a += step) begin
            @(negedge clk);
            wr_req = 1; wr_addr = a[AW-1:0];
        end
        @(negedge clk);
        wr_req = 0;
    endtask

    task automatic edge_writes();
        int pts[4] = '{0, 127, 128, 255};
        foreach (pts[i]) begin
            @(negedge clk);
            wr_req = 1; wr_addr = pts[i][AW-1:0];
        end
        @(negedge clk);
        wr_req = 0;
    endtask

    initial begin
        cyc(3);
        rst_full = 0;
        cyc(2);
        sweep(1);                          // R3 all open
        cmd(3'd4); cmd(3'd5);              // R7 queries, both ACK
        cmd(3'd2);                         // R6 set reversible
        cmd(3'd5);                         // R7 now NACK
        sweep(1);                          // R2 lower half guarded
        cmd(3'd3); edge_writes();          // R6 cleared
        cmd(3'd2);
        @(negedge clk); wp_pin = 1;        // R11 latency
        cyc(3); edge_writes();             // R1
        @(negedge clk); wp_pin = 0;
        cyc(3);
        cmd(3'd0); cmd(3'd6); cmd(3'd7);   // R8
        // command and write in the same cycle: R4 uses old state
        @(negedge clk);
        cmd_valid = 1; cmd_code = 3'd3; wr_req = 1; wr_addr = 8'h10;
        @(negedge clk);
        cmd_valid = 0; wr_req = 1; wr_addr = 8'h10;
        @(negedge clk);
        wr_req = 0;
        cmd(3'd2);
        cmd(3'd1);                         // R5 ACK
        cmd(3'd1);                         // R5 NACK
        cmd(3'd3); cmd(3'd2);              // R6 refused
        cmd(3'd4);                         // R7 NACK
        edge_writes();
        // light reset keeps permanent flag
        @(negedge clk); rst_por = 1;
        cyc(2); rst_por = 0;
        cyc(1);
        chk("R10 perm kept after por", perm_locked, 1);
        chk("R10 rev cleared after por", rev_locked, 0);
        edge_writes();
        cmd(3'd3);                         // still refused
        @(negedge clk); wp_pin = 1;
        cyc(4); edge_writes();
        @(negedge clk); wp_pin = 0;
        // full reset loads PERM_INIT
        @(negedge clk); rst_full = 1;
        cyc(2); rst_full = 0;
        cyc(1);
        chk("R10 perm reloaded by full reset", perm_locked, PINIT);
        edge_writes();
        cmd(3'd2); cmd(3'd3);
        cyc(3);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule